// File: doc/BRIEF.md
# Operand Forwarding Unit

This block picks the two ALU operands for the execute stage of a five-stage pipeline. Two instructions ahead of the one in execute may still hold results that the register file has not received. The first sits in the execute-to-memory register and the second in the memory-to-writeback register. The block compares each source register number of the executing instruction with the destination numbers of those two instructions. For each operand it then chooses the register-file value, the pending ALU result or the pending write-back data.

The logic is purely combinational, so the chosen operands are ready in the same cycle as the inputs. Each operand has its own 2-bit select output as well as its data output. The selects tell the surrounding pipeline where each operand came from.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage write flag is 1, its destination is non-zero and it equals an operand's source number, that operand's select is 2'b10 and the operand equals the memory-stage ALU result.
- R2: When the memory stage does not match under R1, but the write-back stage has its write flag at 1, a non-zero destination and a destination equal to the operand's source number, the select is 2'b01 and the operand equals the write-back data.
- R3: When both stages match an operand under their own conditions, the memory stage (the newer result) wins and the select is 2'b10.
- R4: Operand A is matched using the first source number (rs) and operand B using the second (rt). A stage that matches only one of the two sources changes only that operand.
- R5: A destination of register 0 never causes forwarding, even when its write flag is 1 and the source number is also 0.
- R6: With no match (including a matching destination whose write flag is 0), the select is 2'b00 and the operand equals the register-file value for that source.
- R7: The select code 2'b11 is never produced on either operand.
- R8: The two operands are resolved independently, so in the same cycle one may take the memory-stage result while the other takes the write-back data.
- R9: The outputs follow input changes with no clock edge in between (zero cycles of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_idx | input | 5 | First source register number of the instruction in execute |
| ex_rt_idx | input | 5 | Second source register number of the instruction in execute |
| ex_rs_val | input | 32 | Register-file value read for the first source |
| ex_rt_val | input | 32 | Register-file value read for the second source |
| mem_dst_idx | input | 5 | Destination number held in the execute-to-memory register |
| mem_wr_en | input | 1 | Register write flag of the memory-stage instruction |
| mem_alu_res | input | 32 | ALU result held in the memory stage |
| wb_dst_idx | input | 5 | Destination number held in the memory-to-writeback register |
| wb_wr_en | input | 1 | Register write flag of the write-back-stage instruction |
| wb_data | input | 32 | Data being written back to the register file |
| fwd_sel_a | output | 2 | Source select for operand A (00 file, 01 write-back, 10 memory) |
| fwd_sel_b | output | 2 | Source select for operand B, same coding |
| op_a | output | 32 | Selected operand A |
| op_b | output | 32 | Selected operand B |

## Verification
The bench makes both stages match the same source. A design with the priority reversed would hand over the older write-back data. It drives register 0 as the destination, with its write flag set, against a zero source. A design without the zero guard would forward a value that register 0 can never hold. It also sets a matching destination with its write flag cleared, and matches a stage against only rt. These catch designs that ignore the write flag or cross the two sources. An exhaustive sweep over a small range of register numbers confirms that code 11 never appears and that each operand keeps its own select.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Select codes for one ALU operand; 2'b11 is unused.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;

    localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/fwd_stage_hit.sv
module fwd_stage_hit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] dst_idx,
    input  logic          wr_en,
    output logic          hit
);

    localparam logic [AW-1:0] ZERO_IDX = '0;

    always_comb begin
        hit = wr_en && (dst_idx != ZERO_IDX) && (dst_idx == src_idx);
    end

endmodule

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_idx,
    input  logic [AW-1:0] mem_dst_idx,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] wb_dst_idx,
    input  logic          wb_wr_en,
    output fwd_sel_e      sel
);

    logic mem_hit;
    logic wb_hit;

    fwd_stage_hit #(.AW(AW)) u_mem_hit (
        .src_idx (src_idx),
        .dst_idx (mem_dst_idx),
        .wr_en   (mem_wr_en),
        .hit     (mem_hit)
    );

    fwd_stage_hit #(.AW(AW)) u_wb_hit (
        .src_idx (src_idx),
        .dst_idx (wb_dst_idx),
        .wr_en   (wb_wr_en),
        .hit     (wb_hit)
    );

    // Newer result (memory stage) has priority over write-back.
    always_comb begin
        if (mem_hit)     sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_sel_e      sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] op_val
);

    always_comb begin
        case (sel)
            SEL_MEM: op_val = mem_val;
            SEL_WB:  op_val = wb_val;
            default: op_val = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] ex_rs_idx,
    input  logic [AW-1:0] ex_rt_idx,
    input  logic [DW-1:0] ex_rs_val,
    input  logic [DW-1:0] ex_rt_val,
    input  logic [AW-1:0] mem_dst_idx,
    input  logic          mem_wr_en,
    input  logic [DW-1:0] mem_alu_res,
    input  logic [AW-1:0] wb_dst_idx,
    input  logic          wb_wr_en,
    input  logic [DW-1:0] wb_data,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b
);

    localparam logic [AW-1:0] ZERO_IDX = '0;

    // Operand 0 = A (rs), operand 1 = B (rt)
    logic [AW-1:0] src_idx [NUM_OPERANDS];
    logic [DW-1:0] rf_val  [NUM_OPERANDS];
    fwd_sel_e      sel     [NUM_OPERANDS];
    logic [DW-1:0] op_val  [NUM_OPERANDS];

    assign src_idx[0] = ex_rs_idx;
    assign src_idx[1] = ex_rt_idx;
    assign rf_val[0]  = ex_rs_val;
    assign rf_val[1]  = ex_rt_val;

    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_opnd
        fwd_select #(.AW(AW)) u_sel (
            .src_idx     (src_idx[g]),
            .mem_dst_idx (mem_dst_idx),
            .mem_wr_en   (mem_wr_en),
            .wb_dst_idx  (wb_dst_idx),
            .wb_wr_en    (wb_wr_en),
            .sel         (sel[g])
        );

        fwd_opmux #(.DW(DW)) u_mux (
            .sel     (sel[g]),
            .rf_val  (rf_val[g]),
            .mem_val (mem_alu_res),
            .wb_val  (wb_data),
            .op_val  (op_val[g])
        );

        // Checks relating the selector's decision to the mux output and inputs.
        always_comb begin
            a_r7_no_code3: assert (sel[g] != fwd_sel_e'(2'b11));
            if (sel[g] == SEL_MEM) begin
                a_r1_mem_data: assert (op_val[g] == mem_alu_res);
            end
            if (sel[g] == SEL_WB) begin
                a_r2_wb_data: assert (op_val[g] == wb_data);
            end
            if (sel[g] == SEL_RF) begin
                a_r6_rf_data: assert (op_val[g] == rf_val[g]);
            end
            if (mem_wr_en && mem_dst_idx != ZERO_IDX && mem_dst_idx == src_idx[g]) begin
                a_r3_newer_wins: assert (sel[g] == SEL_MEM);
            end
            if (mem_dst_idx == ZERO_IDX && wb_dst_idx == ZERO_IDX) begin
                a_r5_zero_dst: assert (sel[g] == SEL_RF);
            end
            if (!mem_wr_en && !wb_wr_en) begin
                a_r6_no_write: assert (sel[g] == SEL_RF);
            end
        end
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];
    assign op_a      = op_val[0];
    assign op_b      = op_val[1];

endmodule

// File: tb/fwd_unit_test.sv
module fwd_unit_test;

    logic        clk = 1'b0;
    logic [4:0]  rs, rt, mdst, wdst;
    logic [31:0] rsv, rtv, mres, wdat;
    logic        mwr, wwr;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] op_a, op_b;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    fwd_unit uut (
        .ex_rs_idx   (rs),
        .ex_rt_idx   (rt),
        .ex_rs_val   (rsv),
        .ex_rt_val   (rtv),
        .mem_dst_idx (mdst),
        .mem_wr_en   (mwr),
        .mem_alu_res (mres),
        .wb_dst_idx  (wdst),
        .wb_wr_en    (wwr),
        .wb_data     (wdat),
        .fwd_sel_a   (sel_a),
        .fwd_sel_b   (sel_b),
        .op_a        (op_a),
        .op_b        (op_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [4:0] a_idx, input logic [4:0] b_idx,
                         input logic [4:0] m_dst, input logic m_wr,
                         input logic [4:0] w_dst, input logic w_wr);
        @(negedge clk);
        rs = a_idx; rt = b_idx;
        rsv = 32'hAAAA_0001; rtv = 32'hBBBB_0002;
        mres = 32'hCCCC_0003; wdat = 32'hDDDD_0004;
        mdst = m_dst; mwr = m_wr; wdst = w_dst; wwr = w_wr;
        #5;
    endtask

    task automatic t_idle;
        drive(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
        chk("R6 idle sel_a", 32'(sel_a), 32'd0);
        chk("R6 idle sel_b", 32'(sel_b), 32'd0);
        chk("R6 idle op_a", op_a, 32'hAAAA_0001);
        chk("R6 idle op_b", op_b, 32'hBBBB_0002);
    endtask

    task automatic t_mem_fwd;
        drive(5'd3, 5'd8, 5'd3, 1'b1, 5'd0, 1'b0);
        chk("R1 sel_a", 32'(sel_a), 32'd2);
        chk("R1 op_a", op_a, 32'hCCCC_0003);
        chk("R4 sel_b untouched", 32'(sel_b), 32'd0);
    endtask

    task automatic t_wb_fwd;
        drive(5'd1, 5'd7, 5'd2, 1'b1, 5'd7, 1'b1);
        chk("R2 sel_b", 32'(sel_b), 32'd1);
        chk("R2 op_b", op_b, 32'hDDDD_0004);
        chk("R2 sel_a", 32'(sel_a), 32'd0);
    endtask

    task automatic t_both;
        drive(5'd4, 5'd4, 5'd4, 1'b1, 5'd4, 1'b1);
        chk("R3 sel_a", 32'(sel_a), 32'd2);
        chk("R3 op_a", op_a, 32'hCCCC_0003);
        chk("R3 op_b", op_b, 32'hCCCC_0003);
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        chk("R5 sel_a", 32'(sel_a), 32'd0);
        chk("R5 sel_b", 32'(sel_b), 32'd0);
        chk("R5 op_a", op_a, 32'hAAAA_0001);
        chk("R5 op_b", op_b, 32'hBBBB_0002);
    endtask

    task automatic t_no_write;
        drive(5'd6, 5'd9, 5'd6, 1'b0, 5'd9, 1'b0);
        chk("R6 wr low sel_a", 32'(sel_a), 32'd0);
        chk("R6 wr low op_b", op_b, 32'hBBBB_0002);
    endtask

    task automatic t_rt_only;
        drive(5'd5, 5'd6, 5'd6, 1'b1, 5'd0, 1'b0);
        chk("R4 rt only sel_a", 32'(sel_a), 32'd0);
        chk("R4 rt only sel_b", 32'(sel_b), 32'd2);
        chk("R4 rt only op_a", op_a, 32'hAAAA_0001);
    endtask

    task automatic t_split;
        drive(5'd9, 5'd10, 5'd9, 1'b1, 5'd10, 1'b1);
        chk("R8 sel_a", 32'(sel_a), 32'd2);
        chk("R8 sel_b", 32'(sel_b), 32'd1);
        chk("R8 op_a", op_a, 32'hCCCC_0003);
        chk("R8 op_b", op_b, 32'hDDDD_0004);
    endtask

    task automatic t_no_latency;
        drive(5'd12, 5'd13, 5'd12, 1'b1, 5'd0, 1'b0);
        chk("R9 first", op_a, 32'hCCCC_0003);
        #1 mres = 32'h1234_5678;
        #1 chk("R9 data follows", op_a, 32'h1234_5678);
        wdst = 5'd13; wwr = 1'b1;
        #1 chk("R9 select follows", 32'(sel_b), 32'd1);
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 4; i++)
            for (int m = 0; m < 4; m++)
                for (int w = 0; w < 4; w++)
                    for (int f = 0; f < 4; f++) begin
                        logic [1:0] exp_a;
                        logic [1:0] exp_b;
                        drive(5'(i), 5'(3 - i), 5'(m), f[0], 5'(w), f[1]);
                        if (f[0] && m != 0 && m == i)          exp_a = 2'b10;
                        else if (f[1] && w != 0 && w == i)     exp_a = 2'b01;
                        else                                   exp_a = 2'b00;
                        if (f[0] && m != 0 && m == 3 - i)      exp_b = 2'b10;
                        else if (f[1] && w != 0 && w == 3 - i) exp_b = 2'b01;
                        else                                   exp_b = 2'b00;
                        chk("R7 sweep sel_a", 32'(sel_a), 32'(exp_a));
                        chk("R7 sweep sel_b", 32'(sel_b), 32'(exp_b));
                    end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_mem_fwd();
        t_wb_fwd();
        t_both();
        t_zero();
        t_no_write();
        t_rt_only();
        t_split();
        t_no_latency();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule